// File: doc/BRIEF.md
# Dual-Clock FIFO with Threshold Flags

This block moves 36-bit words from a writer running on one clock to a reader running on another, unrelated clock, through 512 words of storage. The writer sees two status outputs in its own domain: `in_rdy`, which says a write will be taken, and `af_clear`, which drops when the storage is close to full. The reader sees two outputs in its own domain: `out_rdy`, which says a valid word is waiting in the read output register, and `ae_clear`, which rises once the storage holds more than a set number of words.

The head word is moved into a read output register on its own accord whenever that register is empty. A read request (`rd_en` while `out_rdy` is high) consumes that word and lets the next one take its place. A word that sits in the output register no longer occupies storage, so the block can hold one word more than its storage depth. The two threshold offsets are held on static inputs. Pointers cross between the domains as gray codes through two-flop synchronizers, so each flag can lag the true fill level but never claims room or data that is not there.

Top module: `dcfifo_flags`

## Requirements
- R1: While reset is held and after it is released with no writes, `out_rdy` is 0, `ae_clear` is 0, `af_clear` is 1 and `in_rdy` is 1.
- R2: Words leave through `rdata` in exactly the order and with exactly the values they were accepted, with the two clocks at unrelated rates and both sides throttling at random.
- R3: Once settled, `in_rdy` is 0 exactly when storage holds 512 words, and a write offered while `in_rdy` is 0 changes neither the flags nor the data later read out.
- R4: A read offered while `out_rdy` is 0 has no effect: the next word written is still delivered on `rdata`.
- R5: When the output register is empty and storage holds a word, that word appears on `rdata` with `out_rdy` at 1 without any read request; `out_rdy` is 1 exactly when at least one word is held in the block.
- R6: Once settled, `ae_clear` is 1 exactly when the number of words in storage is greater than `ae_off`.
- R7: Once settled, `af_clear` is 0 exactly when the number of words in storage is at least 512 minus `af_off`.
- R8: The word in the output register does not count as stored: with no reads, 513 writes are accepted before `in_rdy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request; taken when `in_rdy` is 1 |
| wdata | input | 36 | Write data |
| af_off | input | 9 | Almost-full offset, static |
| in_rdy | output | 1 | A write will be accepted |
| af_clear | output | 1 | Low when storage is within `af_off` of full |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request; consumes `rdata` when `out_rdy` is 1 |
| ae_off | input | 9 | Almost-empty offset, static |
| rdata | output | 36 | Read output register |
| out_rdy | output | 1 | `rdata` holds a valid word |
| ae_clear | output | 1 | High when storage holds more than `ae_off` words |

## Verification
The threshold assertions assume `ae_off` and `af_off` never change after reset, and the pointer assertions assume both resets are held together for several cycles of each clock before either is released. The stimulus sets the offsets once before reset and releases both resets at the same moment. Flag values are compared only after a settling pause long enough for a pointer change to cross both synchronizers and be registered, since the flags are allowed to lag.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    localparam int DEF_DATA_W = 36;
    localparam int DEF_ADDR_W = 9;

    // Write-domain status bundle
    typedef struct packed {
        logic room;       // a write will be taken
        logic below_af;   // not yet almost full
    } wr_flags_t;

    // Read-domain status bundle
    typedef struct packed {
        logic valid;      // output register holds a word
        logic above_ae;   // storage above almost-empty offset
    } rd_flags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] af_off,
    input  logic [PTR_W-1:0]  rgray_s,
    output wr_flags_t         flags,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, lvl_nx, lvl_now;

    assign push    = wr_en && flags.room;
    assign wbin_nx = wbin + PTR_W'(push);
    assign rbin_s  = PTR_W'(gray_to_bin(32'(rgray_s)));
    assign lvl_nx  = wbin_nx - rbin_s;
    assign lvl_now = wbin - rbin_s;
    assign waddr   = wbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin           <= '0;
            wgray          <= '0;
            flags.room     <= 1'b1;
            flags.below_af <= 1'b1;
        end else begin
            wbin           <= wbin_nx;
            wgray          <= PTR_W'(bin_to_gray(32'(wbin_nx)));
            flags.room     <= (lvl_nx != DEPTH_P);
            flags.below_af <= (lvl_nx < (DEPTH_P - PTR_W'(af_off)));
        end
    end

    // R3: storage never holds more than its depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        lvl_now <= DEPTH_P);
    // R3: room is never claimed while storage is full
    p_room_true_r3: assert property (@(posedge clk) disable iff (rst)
        flags.room |-> (lvl_now < DEPTH_P));
    // R7: not-almost-full is never claimed above the threshold
    p_af_true_r7: assert property (@(posedge clk) disable iff (rst)
        flags.below_af |-> (lvl_now < (DEPTH_P - PTR_W'(af_off))));
    // R2: the crossing pointer changes by at most one bit per clock
    p_gray_onebit_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ae_off,
    input  logic [PTR_W-1:0]  wgray_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [DATA_W-1:0] rdata,
    output rd_flags_t         flags
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

    logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, lvl_nx, lvl_now;
    logic             avail, load;

    assign wbin_s  = PTR_W'(gray_to_bin(32'(wgray_s)));
    assign avail   = (wbin_s != rbin);
    assign load    = avail && (!flags.valid || rd_en);
    assign rbin_nx = rbin + PTR_W'(load);
    assign lvl_nx  = wbin_s - rbin_nx;
    assign lvl_now = wbin_s - rbin;
    assign raddr   = rbin[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin           <= '0;
            rgray          <= '0;
            rdata          <= '0;
            flags.valid    <= 1'b0;
            flags.above_ae <= 1'b0;
        end else begin
            rbin           <= rbin_nx;
            rgray          <= PTR_W'(bin_to_gray(32'(rbin_nx)));
            flags.above_ae <= (lvl_nx > PTR_W'(ae_off));
            if (load) begin
                rdata       <= mem_q;
                flags.valid <= 1'b1;
            end else if (rd_en) begin
                flags.valid <= 1'b0;
            end
        end
    end

    // R4: the read pointer never passes the write pointer
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        lvl_now <= DEPTH_P);
    // R5: a held word is only dropped by a read request
    p_valid_drop_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.valid) |-> $past(rd_en));
    // R6: above-threshold is never claimed with too few words
    p_ae_true_r6: assert property (@(posedge clk) disable iff (rst)
        flags.above_ae |-> (lvl_now > PTR_W'(ae_off)));
    // R2: the crossing pointer changes by at most one bit per clock
    p_gray_onebit_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
    import dcfifo_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] af_off,
    output logic              in_rdy,
    output logic              af_clear,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] ae_off,
    output logic [DATA_W-1:0] rdata,
    output logic              out_rdy,
    output logic              ae_clear
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_q;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
    logic              push;
    wr_flags_t         wflags;
    rd_flags_t         rflags;

    always_ff @(posedge wclk) begin
        if (push) mem[waddr] <= wdata;
    end
    assign mem_q = mem[raddr];

    dcfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wclk), .rst(wrst), .wr_en(wr_en), .af_off(af_off),
        .rgray_s(rgray_s), .flags(wflags), .push(push),
        .waddr(waddr), .wgray(wgray)
    );

    dcfifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(rclk), .rst(rrst), .rd_en(rd_en), .ae_off(ae_off),
        .wgray_s(wgray_s), .mem_q(mem_q), .raddr(raddr),
        .rgray(rgray), .rdata(rdata), .flags(rflags)
    );

    dcfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
    );

    dcfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
    );

    assign in_rdy   = wflags.room;
    assign af_clear = wflags.below_af;
    assign out_rdy  = rflags.valid;
    assign ae_clear = rflags.above_ae;
endmodule

// File: tb/tb_dcfifo_flags.sv
module tb_dcfifo_flags;
    localparam int DW = 36;
    localparam int AW = 9;
    localparam int DEPTH = 512;
    localparam int XOFF = 5;
    localparam int YOFF = 7;

    logic wclk = 0, rclk = 0;
    logic wrst = 1, rrst = 1;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] af_off = AW'(YOFF), ae_off = AW'(XOFF);
    logic in_rdy, af_clear, out_rdy, ae_clear;
    logic [DW-1:0] rdata;

    int nchk = 0, nerr = 0;
    int total = 0;

    always #10 wclk = ~wclk;   // 50 MHz
    always #13 rclk = ~rclk;

    dcfifo_flags dut (
        .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wdata(wdata),
        .af_off(af_off), .in_rdy(in_rdy), .af_clear(af_clear),
        .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .ae_off(ae_off),
        .rdata(rdata), .out_rdy(out_rdy), .ae_clear(ae_clear)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return {4'(i + 3), 32'(i * 32'h9E3779B1)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge wclk);
    endtask

    task automatic check_flags(input int t);
        int st;
        st = (t > 0) ? t - 1 : 0;
        chk("R5 out_rdy", 64'(out_rdy), 64'(t > 0));
        chk("R6 ae_clear", 64'(ae_clear), 64'(st > XOFF));
        chk("R7 af_clear", 64'(af_clear), 64'(st < DEPTH - YOFF));
        chk("R3 in_rdy", 64'(in_rdy), 64'(st < DEPTH));
    endtask

    task automatic write_one(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1; wdata = d;
        @(negedge wclk);
        wr_en = 0;
    endtask

    task automatic read_one(input logic [DW-1:0] exp, input string req);
        @(negedge rclk);
        chk(req, 64'(out_rdy), 64'(1));
        chk(req, 64'(rdata), 64'(exp));
        rd_en = 1;
        @(negedge rclk);
        rd_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (6) @(negedge wclk);
        chk("R1 out_rdy in reset", 64'(out_rdy), 64'(0));
        chk("R1 in_rdy in reset", 64'(in_rdy), 64'(1));
        wrst = 0; rrst = 0;
        settle();
        chk("R1 out_rdy", 64'(out_rdy), 64'(0));
        chk("R1 ae_clear", 64'(ae_clear), 64'(0));
        chk("R1 af_clear", 64'(af_clear), 64'(1));
        chk("R1 in_rdy", 64'(in_rdy), 64'(1));

        // Fill sweep, one word at a time, no reads (R3, R5, R6, R7, R8)
        while (in_rdy && total < 600) begin
            write_one(pat(total));
            total++;
            settle();
            check_flags(total);
            if (total == 1) chk("R5 fall-through word", 64'(rdata), 64'(pat(0)));
        end
        chk("R8 words accepted before full", 64'(total), 64'(DEPTH + 1));

        // R3: write while full is ignored
        write_one(36'hBAD_C0FFE);
        settle();
        check_flags(total);

        // Drain sweep, one read at a time (R2, R3, R5, R6, R7)
        for (int k = 0; k < DEPTH + 1; k++) begin
            read_one(pat(k), "R2 drain data");
            total--;
            settle();
            check_flags(total);
        end

        // R4: reads while empty are ignored
        for (int k = 0; k < 3; k++) begin
            @(negedge rclk); rd_en = 1;
            @(negedge rclk); rd_en = 0;
        end
        settle();
        chk("R4 out_rdy after empty reads", 64'(out_rdy), 64'(0));
        write_one(pat(9999));
        total++;
        settle();
        chk("R4 word after empty reads", 64'(rdata), 64'(pat(9999)));
        check_flags(total);
        read_one(pat(9999), "R4 read after empty reads");
        total--;
        settle();
        check_flags(total);

        // R2: concurrent streaming with throttling on both sides
        fork
            begin
                int wi = 0, cyc = 0;
                while (wi < 300) begin
                    @(negedge wclk);
                    cyc++;
                    if (in_rdy && (cyc % 5 != 2)) begin
                        wr_en = 1; wdata = pat(20000 + wi); wi++;
                    end else begin
                        wr_en = 0;
                    end
                end
                @(negedge wclk); wr_en = 0;
            end
            begin
                int ri = 0, cyc = 0;
                while (ri < 300) begin
                    @(negedge rclk);
                    cyc++;
                    if (out_rdy && (cyc % 3 != 1)) begin
                        chk("R2 stream data", 64'(rdata), 64'(pat(20000 + ri)));
                        rd_en = 1; ri++;
                    end else begin
                        rd_en = 0;
                    end
                end
                @(negedge rclk); rd_en = 0;
            end
        join
        settle();
        check_flags(0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule